// File: doc/BRIEF.md
# CAN Nominal Bit Timer with Edge Synchronization

This block divides a CAN bit into time quanta and places the bit's sample point and transmit point within it. A programmable prescaler sets the quantum length. Four consecutive segments make up each bit: a one-quantum sync segment, a propagation segment, phase 1 and phase 2. The block watches the receive line for recessive-to-dominant transitions. While the frame logic reports an idle bus, such a transition restarts the bit (hard synchronization). At other times a transition moves the bit boundaries by at most a programmable jump width (resynchronization).

The frame logic above consumes three outputs. `sample_stb` is a one-cycle strobe at the sample point. `rx_bit` is the value sampled there, taken either from one sample or as the majority of three. `tx_stb` is a one-cycle strobe at the start of every bit, where the next transmit bit should be driven. All configuration arrives on static input ports. These ports must only change while the block is held in reset. `rx_in` must already be synchronous to `clk`.

Top module: `can_bit_timer`

## Requirements
- R1: While reset is asserted, `rx_bit` is 1 (recessive) and `sample_stb` is 0. The first cycle after reset is the first cycle of a sync segment, so `tx_stb` is high in it.
- R2: A quantum lasts 2×(`cfg_brp`+1) clock cycles. A field value k in `cfg_prop`, `cfg_ph1` or `cfg_ph2` gives k+1 quanta. Without synchronization a bit lasts 1+(prop+1)+(ph1+1)+(ph2+1) quanta, and `tx_stb` pulses for one cycle in the first cycle of each bit.
- R3: `sample_stb` pulses for one cycle in the last cycle of phase 1. `rx_bit` takes the sampled value on the following clock edge and holds it until the next sample strobe.
- R4: With `bus_idle` high, a falling edge of `rx_in` seen outside phase 2 restarts the bit. The cycle after the edge is the first cycle of a new sync segment. No sample strobe occurs in the edge cycle.
- R5: A falling edge seen in phase 2 never causes a hard restart, even with `bus_idle` high. It is handled as a resynchronization instead.
- R6: A falling edge seen in quantum q (counted from 0) of the propagation/phase-1 region lengthens phase 1 by min(q+1, `cfg_sjw`+1) quanta. The field value k of `cfg_sjw` means k+1 quanta.
- R7: A falling edge in phase 2 with r quanta remaining shortens phase 2. If r ≤ `cfg_sjw`+1, the next cycle starts a new bit. Otherwise phase 2 loses `cfg_sjw`+1 quanta.
- R8: While `tx_dom` is high, resynchronization is suppressed, and a falling edge leaves the bit timing unchanged.
- R9: At most one synchronization takes effect per bit. A further falling edge in the same bit has no effect. A falling edge inside the sync segment never resynchronizes.
- R10: With `cfg_triple` = 1, `rx_bit` is the majority of `rx_in` sampled in the last cycle of the two quanta before the sample point and in the sample-point cycle.
- R11: With `cfg_triple` = 0, `rx_bit` is `rx_in` as seen in the sample-point cycle alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_brp | input | BRP_W | Prescaler; quantum = 2×(value+1) cycles |
| cfg_prop | input | SEG_W | Propagation segment, value+1 quanta |
| cfg_ph1 | input | SEG_W | Phase 1, value+1 quanta |
| cfg_ph2 | input | SEG_W | Phase 2, value+1 quanta |
| cfg_sjw | input | SJW_W | Jump width, value+1 quanta |
| cfg_triple | input | 1 | 1 selects three-sample majority |
| bus_idle | input | 1 | Frame logic is waiting for start of frame |
| tx_dom | input | 1 | Node is currently driving a dominant bit |
| rx_in | input | 1 | Synchronized bus receive level, 1 = recessive |
| sample_stb | output | 1 | Sample-point strobe |
| rx_bit | output | 1 | Sampled bit value |
| tx_stb | output | 1 | Bit-start (transmit point) strobe |

## Verification
The bench builds the block with its default parameters (6-bit prescaler, 3-bit segments, 2-bit jump width) and drives two port configurations. The first uses a 2-cycle quantum with 2/3/3 quanta for propagation, phase 1 and phase 2 and a jump width of 2. This makes both branches of phase-2 shortening reachable, along with jump-width clipping during phase-1 lengthening, and places hard-sync edges both inside and after the sample point. The second uses a 4-cycle quantum with single-quantum propagation and phase 1. Here the earliest majority sample falls inside the sync segment, and one-cycle glitches can be aimed at each of the three sample instants.

// File: rtl/can_bit_timer.sv
module can_bit_timer #(
  parameter int BRP_W = 6,
  parameter int SEG_W = 3,
  parameter int SJW_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BRP_W-1:0] cfg_brp,
  input  logic [SEG_W-1:0] cfg_prop,
  input  logic [SEG_W-1:0] cfg_ph1,
  input  logic [SEG_W-1:0] cfg_ph2,
  input  logic [SJW_W-1:0] cfg_sjw,
  input  logic             cfg_triple,
  input  logic             bus_idle,
  input  logic             tx_dom,
  input  logic             rx_in,
  output logic             sample_stb,
  output logic             rx_bit,
  output logic             tx_stb
);
  localparam int PRE_W = BRP_W + 1;
  localparam int T_W   = ((SEG_W > SJW_W) ? SEG_W : SJW_W) + 2;

  typedef enum logic [1:0] {SEG_SYNC, SEG_T1, SEG_T2} seg_t;

  seg_t           seg;
  logic [PRE_W-1:0] pre_cnt;
  logic [T_W-1:0] q_cnt, t1_lim, t2_lim;
  logic           rx_prev, sync_done;
  logic [1:0]     hist;

  wire [PRE_W-1:0] pre_last = {cfg_brp, 1'b1};
  wire             tq_end   = (pre_cnt == pre_last);
  wire [T_W-1:0]   t1_nom   = T_W'(cfg_prop) + T_W'(cfg_ph1) + T_W'(2);
  wire [T_W-1:0]   t2_nom   = T_W'(cfg_ph2) + T_W'(1);
  wire [T_W-1:0]   sjw_q    = T_W'(cfg_sjw) + T_W'(1);
  wire             falling  = rx_prev & ~rx_in;

  wire hard   = falling && bus_idle && !sync_done && (seg != SEG_T2);
  wire resync = falling && !hard && !sync_done && !tx_dom && (seg != SEG_SYNC);

  wire [T_W-1:0] err1  = q_cnt + T_W'(1);
  wire [T_W-1:0] add1  = (resync && seg == SEG_T1) ? ((err1 < sjw_q) ? err1 : sjw_q) : '0;
  wire [T_W-1:0] t1_eff = t1_lim + add1;
  wire [T_W-1:0] rem2  = t2_lim - q_cnt;
  wire jump = resync && (seg == SEG_T2) && (rem2 <= sjw_q);
  wire cut  = resync && (seg == SEG_T2) && !jump;

  logic seg_last;
  always_comb begin
    case (seg)
      SEG_SYNC: seg_last = 1'b1;
      SEG_T1:   seg_last = (q_cnt == t1_eff - T_W'(1));
      default:  seg_last = (q_cnt == t2_lim - T_W'(1));
    endcase
  end

  assign sample_stb = tq_end && (seg == SEG_T1) && seg_last && !hard;
  assign tx_stb     = (seg == SEG_SYNC) && (pre_cnt == '0);

  wire majority = (hist[1] & hist[0]) | (hist[1] & rx_in) | (hist[0] & rx_in);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seg       <= SEG_SYNC;
      pre_cnt   <= '0;
      q_cnt     <= '0;
      t1_lim    <= t1_nom;
      t2_lim    <= t2_nom;
      sync_done <= 1'b0;
    end else if (hard || jump) begin
      seg       <= SEG_SYNC;
      pre_cnt   <= '0;
      q_cnt     <= '0;
      t1_lim    <= t1_nom;
      t2_lim    <= t2_nom;
      sync_done <= hard;
    end else begin
      pre_cnt <= tq_end ? '0 : pre_cnt + PRE_W'(1);
      t1_lim  <= t1_eff;
      if (cut) t2_lim <= t2_lim - sjw_q;
      if (resync) sync_done <= 1'b1;
      if (tq_end) begin
        if (seg_last) begin
          q_cnt <= '0;
          case (seg)
            SEG_SYNC: seg <= SEG_T1;
            SEG_T1:   seg <= SEG_T2;
            default: begin
              seg       <= SEG_SYNC;
              sync_done <= 1'b0;
              t1_lim    <= t1_nom;
              t2_lim    <= t2_nom;
            end
          endcase
        end else begin
          q_cnt <= q_cnt + T_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_prev <= 1'b1;
      hist    <= 2'b11;
      rx_bit  <= 1'b1;
    end else begin
      rx_prev <= rx_in;
      if (tq_end) hist <= {hist[0], rx_in};
      if (sample_stb) rx_bit <= cfg_triple ? majority : rx_in;
    end
  end

  // R3
  ph2_follows_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |=> seg == SEG_T2);
  // R3
  rx_bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_stb |=> $stable(rx_bit));
  // R11
  single_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_stb && !cfg_triple) |=> rx_bit == $past(rx_in));
  // R10
  majority_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_stb && cfg_triple && hist[1] == hist[0]) |=> rx_bit == $past(hist[0]));
  // R7
  jump_new_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    jump |=> tx_stb);
  // R4
  hard_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hard |=> (tx_stb && sync_done));
  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seg == SEG_T2) |-> q_cnt < t2_lim);
endmodule

// File: tb/test_can_bit_timer.sv
`timescale 1ns/1ps
module test_can_bit_timer;
  logic clk = 0, rst_n = 0;
  logic [5:0] cfg_brp = 0;
  logic [2:0] cfg_prop = 0, cfg_ph1 = 0, cfg_ph2 = 0;
  logic [1:0] cfg_sjw = 0;
  logic cfg_triple = 0, bus_idle = 0, tx_dom = 0, rx_in = 1;
  logic sample_stb, rx_bit, tx_stb;

  can_bit_timer i_can_bit_timer (
    .clk(clk), .rst_n(rst_n), .cfg_brp(cfg_brp), .cfg_prop(cfg_prop),
    .cfg_ph1(cfg_ph1), .cfg_ph2(cfg_ph2), .cfg_sjw(cfg_sjw),
    .cfg_triple(cfg_triple), .bus_idle(bus_idle), .tx_dom(tx_dom),
    .rx_in(rx_in), .sample_stb(sample_stb), .rx_bit(rx_bit), .tx_stb(tx_stb));

  always #2.5 clk = ~clk;

  typedef struct { int cyc; logic val; string tag; } ev_t;
  ev_t sq[$];
  ev_t tq[$];
  int cyc = 0, check_until = -1, n_chk = 0, n_bad = 0;
  bit pend = 0;
  ev_t pend_ev;

  always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  task automatic push_s(int c, logic v, string tag);
    ev_t e; e.cyc = c; e.val = v; e.tag = tag; sq.push_back(e);
  endtask
  task automatic push_t(int c, string tag);
    ev_t e; e.cyc = c; e.val = 1'b1; e.tag = tag; tq.push_back(e);
  endtask

  always @(negedge clk) begin
    ev_t e;
    if (!rst_n) pend = 0;
    else begin
      if (pend) begin
        chk(rx_bit === pend_ev.val, {pend_ev.tag, " rx_bit"}, int'(rx_bit), int'(pend_ev.val));
        pend = 0;
      end
      if (cyc <= check_until) begin
        if (tx_stb) begin
          if (tq.size() == 0) chk(0, "R2 unexpected tx_stb", cyc, -1);
          else begin e = tq.pop_front(); chk(e.cyc == cyc, {e.tag, " tx_stb cycle"}, cyc, e.cyc); end
        end
        if (sample_stb) begin
          if (sq.size() == 0) chk(0, "R3 unexpected sample_stb", cyc, -1);
          else begin
            e = sq.pop_front();
            chk(e.cyc == cyc, {e.tag, " sample_stb cycle"}, cyc, e.cyc);
            pend_ev = e; pend = 1;
          end
        end
      end
    end
  end

  task automatic go(int c);
    while (cyc < c) begin @(posedge clk); #1; end
  endtask

  task automatic start(int brp, int prop, int p1, int p2, int sjw, bit tri_en,
                       bit idle, bit txd, logic rx0);
    rst_n = 0; check_until = -1; sq.delete(); tq.delete();
    cfg_brp = 6'(brp); cfg_prop = 3'(prop); cfg_ph1 = 3'(p1); cfg_ph2 = 3'(p2);
    cfg_sjw = 2'(sjw); cfg_triple = tri_en; bus_idle = idle; tx_dom = txd; rx_in = rx0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(rx_bit === 1'b1, "R1 rx_bit in reset", int'(rx_bit), 1);
    chk(sample_stb === 1'b0, "R1 sample_stb in reset", int'(sample_stb), 0);
    @(posedge clk); #1; rst_n = 1;
  endtask

  task automatic finish_test();
    go(check_until + 2);
    chk(sq.size() == 0, "R3 missing sample events", sq.size(), 0);
    chk(tq.size() == 0, "R2 missing tx events", tq.size(), 0);
  endtask

  initial begin
    // config A: Q=2, t1=5 quanta, t2=3 quanta, sjw=2 quanta, bit=18 cycles, sample at +11
    start(0, 1, 2, 2, 1, 0, 0, 0, 1'b1);
    begin
      logic [5:0] pat = 6'b101001;
      check_until = 6*18 - 1;
      for (int b = 0; b < 6; b++) begin
        push_t(b*18, "R2");
        push_s(b*18 + 11, pat[b], "R9 R3");
      end
      for (int b = 0; b < 6; b++) begin go(b*18); rx_in = pat[b]; end
      finish_test();
    end

    // R6 lengthening, clipped and unclipped
    start(0, 1, 2, 2, 1, 0, 0, 0, 1'b1);
    check_until = 60;
    push_t(0, "R2"); push_s(13, 0, "R6"); push_t(20, "R6");
    push_s(35, 0, "R6"); push_t(42, "R6"); push_s(53, 0, "R6"); push_t(60, "R6");
    go(2); rx_in = 0; go(20); rx_in = 1; go(26); rx_in = 0;
    finish_test();

    // R7 shortening: jump and partial cut
    start(0, 1, 2, 2, 1, 0, 0, 0, 1'b1);
    check_until = 47;
    push_t(0, "R2"); push_s(11, 1, "R7"); push_t(15, "R7"); push_s(26, 1, "R7");
    push_t(29, "R7"); push_s(40, 0, "R7"); push_t(47, "R7");
    go(14); rx_in = 0; go(20); rx_in = 1; go(27); rx_in = 0;
    finish_test();

    // R8 transmit-dominant suppression
    start(0, 1, 2, 2, 1, 0, 0, 1, 1'b1);
    check_until = 36;
    push_t(0, "R2"); push_s(11, 0, "R8"); push_t(18, "R8");
    push_s(29, 0, "R8"); push_t(36, "R8");
    go(2); rx_in = 0; go(18); rx_in = 1; go(24); rx_in = 0;
    finish_test();

    // R4 hard sync and R9 second edge ignored
    start(0, 1, 2, 2, 1, 0, 1, 0, 1'b1);
    check_until = 42;
    push_t(0, "R2"); push_t(6, "R4"); push_s(17, 0, "R4 R9");
    push_t(24, "R9"); push_s(35, 0, "R4"); push_t(42, "R9");
    go(5); rx_in = 0; go(8); rx_in = 1; go(10); rx_in = 0;
    finish_test();

    // R5 idle edge in phase 2 resynchronizes, no hard restart
    start(0, 1, 2, 2, 1, 0, 1, 0, 1'b1);
    check_until = 32;
    push_t(0, "R2"); push_s(11, 1, "R5"); push_t(14, "R5");
    push_s(25, 0, "R5"); push_t(32, "R5");
    go(12); rx_in = 0;
    finish_test();

    // config B: Q=4, t1=2 quanta, t2=2 quanta, bit=20 cycles, sample at +11
    start(1, 0, 0, 1, 0, 1, 0, 1, 1'b0);
    check_until = 60;
    push_t(0, "R2"); push_s(11, 0, "R10"); push_t(20, "R2"); push_s(31, 1, "R10");
    push_t(40, "R2"); push_s(51, 0, "R10"); push_t(60, "R2");
    go(11); rx_in = 1; go(12); rx_in = 0;
    go(26); rx_in = 1; go(32); rx_in = 0;
    go(43); rx_in = 1; go(44); rx_in = 0;
    finish_test();

    start(1, 0, 0, 1, 0, 0, 0, 1, 1'b0);
    check_until = 40;
    push_t(0, "R2"); push_s(11, 1, "R11"); push_t(20, "R2");
    push_s(31, 0, "R11"); push_t(40, "R2");
    go(11); rx_in = 1; go(12); rx_in = 0;
    go(23); rx_in = 1; go(24); rx_in = 0;
    finish_test();

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(100000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule